// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block models the device side of a bank of byte-wide, block-erasable NOR flash parts on a 32-bit bus. One copy of a per-lane command engine sits behind each byte lane. All copies share the address and write strobe, and each decodes only its own byte. A host drives bus writes to issue commands and reads `bus_rdata` at any time. What a lane returns on a read depends on its current read mode: the contents of the storage array, the identifier codes, or its status byte.

The engine recognises one-cycle commands and two-cycle sequences. The two-cycle sequences are a setup byte followed by a confirm or data byte. Program, erase and lock changes start a busy timer that stands in for the cell programming time. Lock bits guard individual blocks, and a master lock freezes those lock bits. The storage array is a small behavioural byte memory held in each lane.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, every lane is in array-read mode, every array byte reads 0xFF, no block lock or master lock is set, and the status byte reads 0x80.
- R2: Reads are combinational on `bus_addr`. Command 0xFF selects array reads. Command 0x70 selects status reads. Command 0x90 selects identifier reads: word address 0 returns 0x89, word address 1 (byte address 4) returns `DEV_CODE`, and any other word address returns 0x00.
- R3: Command 0x40 followed by a data write programs the addressed byte to old AND data. From the 0x40 write on, reads return status until a 0xFF command.
- R4: Command 0x20 followed by confirm 0xD0 sets every byte of the addressed block (2^BLK_SH words) to 0xFF and leaves all other blocks unchanged.
- R5: An accepted program, erase or lock operation drives status bit 7 (ready) to 0 for exactly BUSY_CYC cycles after the accepting edge. Bit 7 then returns to 1.
- R6: While a lane is busy, every write to it is ignored, including clear-status and 0xFF. The exception is 0x70, which only selects status reads.
- R7: Command 0x60 followed by 0x01 locks the addressed block, and 0x60 followed by 0xD0 unlocks all blocks. A program aimed at a locked block leaves the array unchanged and sets status bits 4 and 1. An erase aimed at a locked block leaves the array unchanged and sets bits 5 and 1. Neither starts the busy timer.
- R8: Command 0x60 followed by 0xF1 sets the master lock. After that, a set-block-lock sets bits 4 and 1, and a clear-all-locks sets bits 5 and 1. In both cases the lock bits stay unchanged.
- R9: An unrecognised command byte, or a confirm byte after 0x20 or 0x60 that is not a valid one, sets status bits 5 and 4 and selects status reads. A bad confirm after 0x20 erases nothing.
- R10: Command 0x50 clears status bits 5, 4, 3 and 1 and leaves the read mode unchanged.
- R11: Command 0xB0 only selects status reads. Status bits 6, 3, 2 and 0 always read 0.
- R12: Each byte lane decodes and executes its own byte of `bus_wdata`, so lanes may receive different commands or data in the same write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | WORD_AW+2 | Byte address; bits [1:0] ignored |
| bus_wdata | input | LANES*8 | Write data, one command/data byte per lane |
| bus_rdata | output | LANES*8 | Read data per the lane's read mode |

## Verification
Read data is combinational, so an expected read value is due in the same cycle that the address is driven. A write takes effect at the edge that samples it and is visible on reads from the next cycle on. A busy period is due to report not-ready on exactly BUSY_CYC consecutive reads that begin right after the accepting edge, with ready on the read after those. The scoreboard's driver issues one read per cycle, starting one cycle after each write, and the monitor compares on the falling edge of that same cycle, so each expected value lines up with these latencies exactly.

// File: rtl/flcmd_pkg.sv
// Shared command codes, read modes and sequence states for the flash
// command decoder. Assumes byte-wide command values on each lane.
package flcmd_pkg;
    localparam logic [7:0] OP_RD_ARRAY    = 8'hFF;
    localparam logic [7:0] OP_RD_IDENT    = 8'h90;
    localparam logic [7:0] OP_RD_STATUS   = 8'h70;
    localparam logic [7:0] OP_CLR_STATUS  = 8'h50;
    localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [7:0] OP_LOCK_SETUP  = 8'h60;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_LOCK_BLOCK  = 8'h01;
    localparam logic [7:0] OP_LOCK_MASTER = 8'hF1;
    localparam logic [7:0] MFR_CODE       = 8'h89;

    typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_t;
    typedef enum logic [1:0] {SQ_CMD, SQ_PROG, SQ_ERASE, SQ_LOCK} seq_t;
endpackage

// File: rtl/flcmd_timer.sv
// Busy timer: a start pulse loads BUSY_CYC and the count runs down to zero.
// Assumes start is only raised while the timer is idle.
module flcmd_timer #(
    parameter int BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    logic [CW-1:0] cnt_q;

    // load on start, count down while non-zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= CW'(BUSY_CYC);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/flcmd_store.sv
// Behavioural byte array for one lane: AND-programming of one word and
// whole-block erase to 0xFF. Assumes prog_en and erase_en are exclusive.
module flcmd_store #(
    parameter int WORD_AW = 6,
    parameter int BLK_SH  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_AW-1:0] waddr,
    input  logic               prog_en,
    input  logic [7:0]         prog_data,
    input  logic               erase_en,
    output logic [7:0]         rdata
);
    localparam int DEPTH = 1 << WORD_AW;
    logic [7:0] mem_q [DEPTH];

    // reset to erased, then program (clear bits) or erase (block to 0xFF)
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem_q[i] <= 8'hFF;
            else if (erase_en && ((WORD_AW'(i) >> BLK_SH) == (waddr >> BLK_SH)))
                mem_q[i] <= 8'hFF;
            else if (prog_en && (WORD_AW'(i) == waddr))
                mem_q[i] <= mem_q[i] & prog_data;
        end
    end

    assign rdata = mem_q[waddr];
endmodule

// File: rtl/flcmd_lane.sv
// One byte lane: command decoder, status flags, lock bits, busy timer and
// storage. Assumes the word address is stable for both cycles of a sequence.
module flcmd_lane
    import flcmd_pkg::*;
#(
    parameter int         WORD_AW  = 6,
    parameter int         BLK_SH   = 3,
    parameter int         BUSY_CYC = 8,
    parameter logic [7:0] DEV_CODE = 8'hA6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [WORD_AW-1:0] waddr,
    input  logic [7:0]         wbyte,
    output logic [7:0]         rbyte,
    output logic               busy_o,
    output logic               pend_o,
    output logic [7:0]         status_o
);
    localparam int NBLK = 1 << (WORD_AW - BLK_SH);

    rmode_t            mode_q, mode_n;
    seq_t              seq_q, seq_n;
    logic              err_e_q, err_e_n, err_p_q, err_p_n, prot_q, prot_n;
    logic [NBLK-1:0]   lock_q, lock_n;
    logic              master_q, master_n;
    logic              start, prog_en, erase_en, busy;
    logic [7:0]        arr_byte;
    logic [WORD_AW-BLK_SH-1:0] blk;

    assign blk = waddr[WORD_AW-1:BLK_SH];

    flcmd_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
    );

    flcmd_store #(.WORD_AW(WORD_AW), .BLK_SH(BLK_SH)) u_store (
        .clk(clk), .rst_n(rst_n), .waddr(waddr), .prog_en(prog_en),
        .prog_data(wbyte), .erase_en(erase_en), .rdata(arr_byte)
    );

    // decode a bus write into next state, flag updates and array actions
    always_comb begin
        mode_n = mode_q;  seq_n = seq_q;
        err_e_n = err_e_q; err_p_n = err_p_q; prot_n = prot_q;
        lock_n = lock_q;  master_n = master_q;
        start = 1'b0; prog_en = 1'b0; erase_en = 1'b0;
        if (we && busy) begin
            if (wbyte == OP_RD_STATUS) mode_n = RM_STATUS;
        end else if (we) begin
            unique case (seq_q)
                SQ_CMD: begin
                    case (wbyte)
                        OP_RD_ARRAY:    mode_n = RM_ARRAY;
                        OP_RD_IDENT:    mode_n = RM_IDENT;
                        OP_RD_STATUS:   mode_n = RM_STATUS;
                        OP_SUSPEND:     mode_n = RM_STATUS;
                        OP_CLR_STATUS:  begin err_e_n = 1'b0; err_p_n = 1'b0; prot_n = 1'b0; end
                        OP_PROG_SETUP:  begin seq_n = SQ_PROG;  mode_n = RM_STATUS; end
                        OP_ERASE_SETUP: begin seq_n = SQ_ERASE; mode_n = RM_STATUS; end
                        OP_LOCK_SETUP:  begin seq_n = SQ_LOCK;  mode_n = RM_STATUS; end
                        default:        begin err_e_n = 1'b1; err_p_n = 1'b1; mode_n = RM_STATUS; end
                    endcase
                end
                SQ_PROG: begin
                    seq_n = SQ_CMD;
                    if (lock_q[blk]) begin err_p_n = 1'b1; prot_n = 1'b1; end
                    else begin prog_en = 1'b1; start = 1'b1; end
                end
                SQ_ERASE: begin
                    seq_n = SQ_CMD;
                    if (wbyte != OP_CONFIRM) begin err_e_n = 1'b1; err_p_n = 1'b1; end
                    else if (lock_q[blk]) begin err_e_n = 1'b1; prot_n = 1'b1; end
                    else begin erase_en = 1'b1; start = 1'b1; end
                end
                SQ_LOCK: begin
                    seq_n = SQ_CMD;
                    case (wbyte)
                        OP_LOCK_BLOCK:
                            if (master_q) begin err_p_n = 1'b1; prot_n = 1'b1; end
                            else begin lock_n[blk] = 1'b1; start = 1'b1; end
                        OP_LOCK_MASTER: begin master_n = 1'b1; start = 1'b1; end
                        OP_CONFIRM:
                            if (master_q) begin err_e_n = 1'b1; prot_n = 1'b1; end
                            else begin lock_n = '0; start = 1'b1; end
                        default: begin err_e_n = 1'b1; err_p_n = 1'b1; end
                    endcase
                end
            endcase
        end
    end

    // state and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RM_ARRAY; seq_q <= SQ_CMD;
            err_e_q <= 1'b0; err_p_q <= 1'b0; prot_q <= 1'b0;
            lock_q <= '0; master_q <= 1'b0;
        end else begin
            mode_q <= mode_n; seq_q <= seq_n;
            err_e_q <= err_e_n; err_p_q <= err_p_n; prot_q <= prot_n;
            lock_q <= lock_n; master_q <= master_n;
        end
    end

    assign status_o = {~busy, 1'b0, err_e_q, err_p_q, 1'b0, 1'b0, prot_q, 1'b0};
    assign busy_o   = busy;
    assign pend_o   = (seq_q != SQ_CMD);

    // read data select by mode; a pending sequence always reads status
    always_comb begin
        if (seq_q != SQ_CMD || mode_q == RM_STATUS) rbyte = status_o;
        else if (mode_q == RM_IDENT)
            rbyte = (waddr == '0) ? MFR_CODE :
                    (waddr == WORD_AW'(1)) ? DEV_CODE : 8'h00;
        else rbyte = arr_byte;
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top: LANES identical command lanes behind a shared word address.
// Assumes the two low address bits select nothing (whole-word access).
module flash_cmd_decoder #(
    parameter int         LANES    = 4,
    parameter int         WORD_AW  = 6,
    parameter int         BLK_SH   = 3,
    parameter int         BUSY_CYC = 8,
    parameter logic [7:0] DEV_CODE = 8'hA6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [WORD_AW+1:0]   bus_addr,
    input  logic [LANES*8-1:0]   bus_wdata,
    output logic [LANES*8-1:0]   bus_rdata
);
    logic [WORD_AW-1:0] waddr;
    logic [LANES-1:0]   busy_vec, pend_vec;
    logic [LANES*8-1:0] stat_vec;
    logic               addr_lsb_unused;

    assign waddr           = bus_addr[WORD_AW+1:2];
    assign addr_lsb_unused = ^bus_addr[1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        flcmd_lane #(
            .WORD_AW(WORD_AW), .BLK_SH(BLK_SH),
            .BUSY_CYC(BUSY_CYC), .DEV_CODE(DEV_CODE)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .we(bus_we), .waddr(waddr),
            .wbyte(bus_wdata[g*8 +: 8]), .rbyte(bus_rdata[g*8 +: 8]),
            .busy_o(busy_vec[g]), .pend_o(pend_vec[g]),
            .status_o(stat_vec[g*8 +: 8])
        );
    end
endmodule

// File: rtl/flcmd_checker.sv
// Property checker for the decoder, bound to the top. Assumes BUSY_CYC >= 1.
module flcmd_checker #(
    parameter int LANES    = 4,
    parameter int BUSY_CYC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [LANES*8-1:0] bus_wdata,
    input logic [LANES-1:0]   busy_vec,
    input logic [LANES-1:0]   pend_vec,
    input logic [LANES*8-1:0] stat_vec
);
    localparam int RW = $clog2(BUSY_CYC + 2);

    function automatic logic is_known(input logic [7:0] b);
        return b inside {8'hFF, 8'h90, 8'h70, 8'h50, 8'h40, 8'h20, 8'h60, 8'hB0};
    endfunction

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        logic [RW-1:0] run_q;
        logic [7:0]    st;
        logic [7:0]    wb;
        assign st = stat_vec[g*8 +: 8];
        assign wb = bus_wdata[g*8 +: 8];

        // count consecutive busy cycles
        always_ff @(posedge clk) begin
            if (!rst_n || !busy_vec[g]) run_q <= '0;
            else                        run_q <= run_q + 1'b1;
        end

        assert_reset_idle_R1: assert property (@(posedge clk)
            !rst_n |=> (!busy_vec[g] && st[5:1] == 5'b0));
        assert_busy_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
            busy_vec[g] |-> run_q < RW'(BUSY_CYC));
        assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy_vec[g]) |-> run_q == RW'(BUSY_CYC));
        assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_vec[g] && bus_we) |=> $stable(st[6:0]));
        assert_protect_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st[1]) |-> !busy_vec[g]);
        assert_bad_cmd_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && !busy_vec[g] && !pend_vec[g] && !is_known(wb)) |=> (st[5] && st[4]));
    end
endmodule

bind flash_cmd_decoder flcmd_checker #(.LANES(LANES), .BUSY_CYC(BUSY_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .busy_vec(busy_vec), .pend_vec(pend_vec), .stat_vec(stat_vec)
);

// File: tb/sim_flash_cmd_decoder.sv
// Scoreboard bench: driver tasks queue expected reads, a monitor compares.
module sim_flash_cmd_decoder;
    localparam int BUSY = 8;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    flash_cmd_decoder #(.LANES(4), .WORD_AW(6), .BLK_SH(3), .BUSY_CYC(BUSY),
                        .DEV_CODE(8'hA6)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // monitor: compare one queued expectation per cycle at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (bus_rdata !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        sb_q.push_back('{exp: e, tag: tag});
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 32'hFFFFFFFF, "R1 array erased");
        wr(8'h00, 32'h70707070);
        rd(8'h00, 32'h80808080, "R1 status clean");
        // R2 identifier
        wr(8'h00, 32'h90909090);
        rd(8'h00, 32'h89898989, "R2 manufacturer");
        rd(8'h04, 32'hA6A6A6A6, "R2 device");
        rd(8'h08, 32'h00000000, "R2 other id word");
        wr(8'h00, 32'hFFFFFFFF);
        rd(8'h00, 32'hFFFFFFFF, "R2 back to array");
        // R3 program, R5 busy timing, R12 per-lane data
        wr(8'h10, 32'h40404040);
        rd(8'h10, 32'h80808080, "R3 setup reads status");
        wr(8'h10, 32'h12345678);
        for (int k = 0; k < BUSY; k++) rd(8'h10, 32'h00000000, "R5 busy");
        rd(8'h10, 32'h80808080, "R5 ready again");
        wr(8'h10, 32'hFFFFFFFF);
        rd(8'h10, 32'h12345678, "R12 lane data");
        wr(8'h10, 32'h40404040);
        wr(8'h10, 32'hF0F0F0F0);
        idle(BUSY + 2);
        wr(8'h10, 32'hFFFFFFFF);
        rd(8'h10, 32'h10305070, "R3 AND program");
        // R6 writes ignored while busy
        wr(8'h14, 32'h40404040);
        wr(8'h14, 32'h00000000);
        wr(8'h14, 32'h50505050);
        wr(8'h14, 32'hFFFFFFFF);
        rd(8'h14, 32'h00000000, "R6 still busy status");
        idle(BUSY);
        rd(8'h14, 32'h80808080, "R6 reset ignored");
        wr(8'h14, 32'hFFFFFFFF);
        rd(8'h14, 32'h00000000, "R6 programmed");
        // R4 erase block 0, block 1 kept
        wr(8'h20, 32'h40404040);
        wr(8'h20, 32'h00000000);
        idle(BUSY + 2);
        wr(8'h04, 32'h20202020);
        wr(8'h04, 32'hD0D0D0D0);
        idle(BUSY + 2);
        wr(8'h00, 32'hFFFFFFFF);
        rd(8'h10, 32'hFFFFFFFF, "R4 erased word");
        rd(8'h14, 32'hFFFFFFFF, "R4 erased word 2");
        rd(8'h20, 32'h00000000, "R4 other block kept");
        // R9 bad confirm and unknown command, R10 clear status
        wr(8'h20, 32'h20202020);
        wr(8'h20, 32'h55555555);
        rd(8'h20, 32'hB0B0B0B0, "R9 bad confirm flags");
        wr(8'h20, 32'hFFFFFFFF);
        rd(8'h20, 32'h00000000, "R9 no erase");
        wr(8'h20, 32'h50505050);
        rd(8'h20, 32'h00000000, "R10 mode kept");
        wr(8'h20, 32'h70707070);
        rd(8'h20, 32'h80808080, "R10 flags cleared");
        wr(8'h00, 32'h33333333);
        rd(8'h00, 32'hB0B0B0B0, "R9 unknown command");
        wr(8'h00, 32'h50505050);
        // R7 block lock
        wr(8'h40, 32'h60606060);
        wr(8'h40, 32'h01010101);
        idle(BUSY + 2);
        wr(8'h44, 32'h40404040);
        wr(8'h44, 32'h00000000);
        rd(8'h44, 32'h92929292, "R7 program locked");
        wr(8'h44, 32'h50505050);
        wr(8'h44, 32'h20202020);
        wr(8'h44, 32'hD0D0D0D0);
        rd(8'h44, 32'hA2A2A2A2, "R7 erase locked");
        wr(8'h44, 32'h50505050);
        wr(8'h44, 32'hFFFFFFFF);
        rd(8'h44, 32'hFFFFFFFF, "R7 array untouched");
        wr(8'h00, 32'h60606060);
        wr(8'h00, 32'hD0D0D0D0);
        idle(BUSY + 2);
        wr(8'h44, 32'h40404040);
        wr(8'h44, 32'h00000000);
        idle(BUSY + 2);
        wr(8'h44, 32'hFFFFFFFF);
        rd(8'h44, 32'h00000000, "R7 unlocked program");
        // R8 master lock
        wr(8'h00, 32'h60606060);
        wr(8'h00, 32'hF1F1F1F1);
        idle(BUSY + 2);
        wr(8'h40, 32'h60606060);
        wr(8'h40, 32'h01010101);
        rd(8'h40, 32'h92929292, "R8 set lock refused");
        wr(8'h40, 32'h50505050);
        wr(8'h40, 32'h60606060);
        wr(8'h40, 32'hD0D0D0D0);
        rd(8'h40, 32'hA2A2A2A2, "R8 clear locks refused");
        wr(8'h40, 32'h50505050);
        wr(8'h48, 32'h40404040);
        wr(8'h48, 32'h00000000);
        idle(BUSY + 2);
        wr(8'h48, 32'hFFFFFFFF);
        rd(8'h48, 32'h00000000, "R8 block stayed unlocked");
        // R11 suspend selects status only
        wr(8'h00, 32'hB0B0B0B0);
        rd(8'h00, 32'h80808080, "R11 suspend status");
        // R12 lanes decode independently
        wr(8'h00, 32'hFF90FF70);
        rd(8'h00, 32'hFF89FF80, "R12 mixed modes");
        idle(2);
        done = 1'b1;
        finish_run();
    end
endmodule